// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and calendar date in packed BCD: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A 7-bit binary sub-second counter advances on every pulse of an external 128 Hz tick. When it wraps, the seconds count advances, and the carry ripples through minutes, hours, weekday, date, month and year. Month lengths and leap years are taken into account.

Software reaches every field over a byte-wide register port with a 4-bit index. To set the time, software first stops the counter and holds the prescaler in reset. It then writes the fields and starts the counter again. A carry flag sets each time the seconds advance. A multi-byte read can therefore clear the flag, read the fields, and re-read if the flag came back. The flag can also raise an interrupt. A self-clearing adjust request rounds the seconds to the nearest minute.

Top module: `cal_rtc`

## Requirements
- R1: After reset, the fields are as follows:
  - sub-second, seconds, minutes, hours, weekday and year are 00;
  - day of month and month are 01;
  - both control registers read 00;
  - `carry_irq` is low.
- R2: Counting needs three conditions: start (index 15 bit 0) = 1, enable (index 15 bit 3) = 1 and prescaler reset (index 15 bit 1) = 0. While counting, each cycle with `tick_128` high adds one to the sub-second counter (index 0, binary, bits 6:0).
- R3: The tick that finds the sub-second counter at 127 does three things: it wraps the counter to 0, it advances the seconds by one in BCD, and it sets the carry flag (index 14 bit 7).
- R4: Carries ripple as follows:
  - seconds 59 goes to 00 and advances the minutes;
  - minutes 59 goes to 00 and advances the hours;
  - hours 23 goes to 00 and advances the weekday and the day of month;
  - weekday 6 goes to 0.
- R5: The day of month rolls from the month's last day to 01 and advances the month. The last day is:
  - 30 for months 04, 06, 09 and 11;
  - 29 for month 02 when the year is a multiple of 4 (00 included);
  - 28 for month 02 in any other year;
  - 31 otherwise.
  Month 12 rolls to 01 and advances the year, and year 99 rolls to 00.
- R6: Writing index 14 with bit 7 = 0 clears the carry flag. Writing bit 7 = 1 leaves the flag unchanged.
- R7: Index 14 bit 4 is the carry interrupt enable. `carry_irq` is high exactly while the carry flag and this enable are both 1.
- R8: Writes to the fields at indices 1 to 7 are ignored while start is 1. A write to index 0 is always ignored.
- R9: With start = 0 and no adjust pending, the fields and the sub-second counter hold. With prescaler reset = 1, the sub-second counter is cleared to 0.
- R10: Writing index 15 with bit 2 = 1 requests an adjust. One cycle later the seconds become 00, and seconds of 30 or more also carry one into the minutes, rippling as in R4. The bit then reads 0 again.
- R11: Index 15 reads back start, prescaler reset, adjust and enable in bits 0 to 3. Its bits 7:4 read 0, as do index 14 bits 6:5 and 3:0.
- R12: With enable = 0, ticks do not count, even when start = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_128 | input | 1 | One-cycle pulse at 128 Hz |
| bus_addr | input | 4 | Register index for read and write |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the indexed register, combinational |
| carry_irq | output | 1 | Carry interrupt request |

## Verification
The bench drives every rollover boundary from one second before midnight:
- months of 30 and 31 days;
- February in years that are multiples of 4 and in years that are not, including 00, 10 and 16, where a tens-digit parity slip in the leap test would show;
- the year wrapping from 99.

A wrong last-day table or leap test would give a day such as 31 April or 29 February 2023. A missing year wrap would leave a non-BCD byte.

The adjust is checked on both sides of 30 seconds. A design that always or never carries would give the wrong minute.

Writes are tried while the counter runs. Ticks are sent while it is stopped or not enabled. Either mistake would let the fields move.

The carry flag is checked against clear and keep writes. A design that treats written ones as a clear would lose the torn-read signal.

// File: rtl/cal_pkg.sv
// Shared register indices, the time record and BCD helper functions
// for the calendar counter. Assumes all calendar bytes hold valid BCD.
package cal_pkg;

    localparam logic [3:0] IDX_SUB  = 4'd0;
    localparam logic [3:0] IDX_SEC  = 4'd1;
    localparam logic [3:0] IDX_MIN  = 4'd2;
    localparam logic [3:0] IDX_HOUR = 4'd3;
    localparam logic [3:0] IDX_WDAY = 4'd4;
    localparam logic [3:0] IDX_MDAY = 4'd5;
    localparam logic [3:0] IDX_MON  = 4'd6;
    localparam logic [3:0] IDX_YEAR = 4'd7;
    localparam logic [3:0] IDX_CTL1 = 4'd14;
    localparam logic [3:0] IDX_CTL2 = 4'd15;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] mday;
        logic [7:0] wday;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_time_t;

    // Adds one to a two-digit packed BCD byte (no range wrap).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return v + 8'd1;
    endfunction

    // True for a BCD year that is a multiple of four (00 counts).
    function automatic logic is_leap(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    // Last day of the given BCD month, in BCD.
    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] y);
        case (mon)
            8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_subsec.sv
// Sub-second prescaler: a binary counter stepped by the 128 Hz tick.
// It emits a one-cycle seconds pulse on the tick that wraps it.
// Assumes run is already low whenever hold is high.
module cal_subsec #(
    parameter int SUB_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             hold,
    output logic [SUB_W-1:0] sub,
    output logic             sec_tick
);
    localparam logic [SUB_W-1:0] SUB_MAX = '1;

    // Seconds pulse: a counting tick that lands on the last count.
    assign sec_tick = run & tick & (sub == SUB_MAX);

    // Count ticks, wrap on the seconds pulse, clear while held.
    always_ff @(posedge clk) begin
        if (!rst_n)           sub <= '0;
        else if (hold)        sub <= '0;
        else if (run && tick) sub <= sec_tick ? '0 : sub + 1'b1;
    end
endmodule

// File: rtl/cal_chain.sv
// BCD calendar chain: holds the time record and applies, in order of
// priority, a field write, a 30-second adjust or a seconds step.
// Assumes writes arrive only while the counter is stopped.
module cal_chain
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       adj_go,
    input  logic       wr_en,
    input  logic [3:0] wr_idx,
    input  logic [7:0] wr_data,
    output cal_time_t  now
);
    cal_time_t nxt;

    // Advances the minutes and ripples into hours, days, month and year.
    function automatic cal_time_t carry_minute(input cal_time_t t);
        cal_time_t r;
        r = t;
        if (t.min != 8'h59) r.min = bcd_inc(t.min);
        else begin
            r.min = 8'h00;
            if (t.hour != 8'h23) r.hour = bcd_inc(t.hour);
            else begin
                r.hour = 8'h00;
                r.wday = (t.wday >= 8'h06) ? 8'h00 : t.wday + 8'h01;
                if (t.mday != month_last(t.mon, t.year)) r.mday = bcd_inc(t.mday);
                else begin
                    r.mday = 8'h01;
                    if (t.mon != 8'h12) r.mon = bcd_inc(t.mon);
                    else begin
                        r.mon  = 8'h01;
                        r.year = (t.year == 8'h99) ? 8'h00 : bcd_inc(t.year);
                    end
                end
            end
        end
        return r;
    endfunction

    // Next-state selection: write, else adjust, else seconds step.
    always_comb begin
        nxt = now;
        if (wr_en) begin
            case (wr_idx)
                IDX_SEC:  nxt.sec  = wr_data;
                IDX_MIN:  nxt.min  = wr_data;
                IDX_HOUR: nxt.hour = wr_data;
                IDX_WDAY: nxt.wday = wr_data;
                IDX_MDAY: nxt.mday = wr_data;
                IDX_MON:  nxt.mon  = wr_data;
                IDX_YEAR: nxt.year = wr_data;
                default:  ;
            endcase
        end else if (adj_go) begin
            nxt.sec = 8'h00;
            if (now.sec >= 8'h30) nxt = carry_minute(nxt);
        end else if (sec_tick) begin
            if (now.sec == 8'h59) begin
                nxt.sec = 8'h00;
                nxt = carry_minute(nxt);
            end else begin
                nxt.sec = bcd_inc(now.sec);
            end
        end
    end

    // Time record register with the calendar's reset date.
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '{year: 8'h00, mon: 8'h01, mday: 8'h01, wday: 8'h00,
                             hour: 8'h00, min: 8'h00, sec: 8'h00};
        else        now <= nxt;
    end
endmodule

// File: rtl/cal_rtc.sv
// Calendar counter top: byte register port, two control registers,
// the carry flag and its interrupt, around the prescaler and the chain.
// Assumes tick_128 is a single-cycle pulse and that SUB_W is at most 8.
module cal_rtc
    import cal_pkg::*;
#(
    parameter int SUB_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_128,
    input  logic [3:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       carry_irq
);
    logic             start, prst, en, adj_pend, cf, cie;
    logic             run, sec_tick, wr_time, wr_c1, wr_c2;
    logic [SUB_W-1:0] sub_cnt;
    cal_time_t        now_t;

    // Decode of the strobes and of the counting condition.
    assign run     = start & en & ~prst;
    assign wr_c1   = bus_wr && (bus_addr == IDX_CTL1);
    assign wr_c2   = bus_wr && (bus_addr == IDX_CTL2);
    assign wr_time = bus_wr && !start && (bus_addr >= IDX_SEC) && (bus_addr <= IDX_YEAR);

    cal_subsec #(.SUB_W(SUB_W)) u_sub (
        .clk(clk), .rst_n(rst_n), .tick(tick_128), .run(run), .hold(prst),
        .sub(sub_cnt), .sec_tick(sec_tick)
    );

    cal_chain u_chain (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .adj_go(adj_pend),
        .wr_en(wr_time), .wr_idx(bus_addr), .wr_data(bus_wdata), .now(now_t)
    );

    // Control 2 bits; the adjust request lives for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start <= 1'b0; prst <= 1'b0; en <= 1'b0; adj_pend <= 1'b0;
        end else if (wr_c2) begin
            start    <= bus_wdata[0];
            prst     <= bus_wdata[1];
            adj_pend <= bus_wdata[2];
            en       <= bus_wdata[3];
        end else begin
            adj_pend <= 1'b0;
        end
    end

    // Carry flag: set by a seconds step (wins), cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cf <= 1'b0;
        else if (sec_tick)               cf <= 1'b1;
        else if (wr_c1 && !bus_wdata[7]) cf <= 1'b0;
    end

    // Carry interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)     cie <= 1'b0;
        else if (wr_c1) cie <= bus_wdata[4];
    end

    assign carry_irq = cf & cie;

    // Read multiplexer over the register indices.
    always_comb begin
        bus_rdata = 8'h00;
        case (bus_addr)
            IDX_SUB:  bus_rdata[SUB_W-1:0] = sub_cnt;
            IDX_SEC:  bus_rdata = now_t.sec;
            IDX_MIN:  bus_rdata = now_t.min;
            IDX_HOUR: bus_rdata = now_t.hour;
            IDX_WDAY: bus_rdata = now_t.wday;
            IDX_MDAY: bus_rdata = now_t.mday;
            IDX_MON:  bus_rdata = now_t.mon;
            IDX_YEAR: bus_rdata = now_t.year;
            IDX_CTL1: bus_rdata = {cf, 2'b00, cie, 4'b0000};
            IDX_CTL2: bus_rdata = {4'b0000, en, adj_pend, prst, start};
            default:  bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/cal_rtc_chk.sv
// Property checker for cal_rtc, attached by the bind below.
module cal_rtc_chk #(
    parameter int SUB_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             tick,
    input logic [SUB_W-1:0] sub,
    input logic             sec_tick,
    input logic             cf,
    input logic             prst,
    input logic             start,
    input logic             adj_pend,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic [7:0]       bus_wdata,
    input logic [55:0]      time_flat
);
    localparam logic [SUB_W-1:0] SUB_MAX = '1;

    AST_SUB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && sub != SUB_MAX) |=> (sub == $past(sub) + 1'b1)); // R2

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && sub == SUB_MAX) |=> (sub == '0 && cf)); // R3

    AST_PRESC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        prst |=> (sub == '0)); // R9

    AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !bus_wr && !adj_pend) |=> $stable(time_flat)); // R9

    AST_ADJ_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_pend && !(bus_wr && bus_addr == 4'd15)) |=> !adj_pend); // R10

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cf && !sec_tick && bus_wr && bus_addr == 4'd14 && !bus_wdata[7]) |=> !cf); // R6
endmodule

bind cal_rtc cal_rtc_chk #(.SUB_W(SUB_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick_128), .sub(sub_cnt),
    .sec_tick(sec_tick), .cf(cf), .prst(prst), .start(start), .adj_pend(adj_pend),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .time_flat(now_t)
);

// File: tb/cal_rtc_tb.sv
// Directed bench for cal_rtc: one task per scenario, each checking itself.
module cal_rtc_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_128 = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       carry_irq;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2 clk = ~clk;

    cal_rtc u_dut (
        .clk(clk), .rst_n(rst_n), .tick_128(tick_128), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .carry_irq(carry_irq)
    );

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick_128 = 1'b1;
        repeat (n) @(negedge clk);
        tick_128 = 1'b0;
    endtask

    task automatic chk_reg(input logic [3:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a; #1;
        n_chk++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: index %0d got %02h expected %02h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        #1; n_chk++;
        if (carry_irq !== exp) begin
            n_bad++;
            $display("FAIL %s: carry_irq got %0b expected %0b", tag, carry_irq, exp);
        end
    endtask

    // Stop with prescaler reset, load all fields, restart counting.
    task automatic set_time(input logic [7:0] s, mi, h, wd, md, mo, y);
        wr(4'd15, 8'h0A);
        wr(4'd1, s); wr(4'd2, mi); wr(4'd3, h); wr(4'd4, wd);
        wr(4'd5, md); wr(4'd6, mo); wr(4'd7, y);
        wr(4'd15, 8'h09);
        wr(4'd14, 8'h00);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk_reg(4'd0, 8'h00, "R1 subsec");
        chk_reg(4'd1, 8'h00, "R1 sec");
        chk_reg(4'd3, 8'h00, "R1 hour");
        chk_reg(4'd5, 8'h01, "R1 mday");
        chk_reg(4'd6, 8'h01, "R1 month");
        chk_reg(4'd7, 8'h00, "R1 year");
        chk_reg(4'd14, 8'h00, "R1 ctrl1");
        chk_reg(4'd15, 8'h00, "R1 ctrl2");
        chk_irq(1'b0, "R1 irq");
    endtask

    task automatic t_subsec;
        set_time(8'h10, 8'h20, 8'h08, 8'h02, 8'h14, 8'h06, 8'h21);
        chk_reg(4'd0, 8'h00, "R2 subsec start");
        ticks(5);
        chk_reg(4'd0, 8'h05, "R2 subsec after 5");
        chk_reg(4'd1, 8'h10, "R2 sec held");
        chk_reg(4'd14, 8'h00, "R3 flag clear before wrap");
        ticks(123);
        chk_reg(4'd0, 8'h00, "R3 subsec wrap");
        chk_reg(4'd1, 8'h11, "R3 sec step");
        chk_reg(4'd14, 8'h80, "R3 flag set");
    endtask

    task automatic t_flag;
        wr(4'd14, 8'h80);
        chk_reg(4'd14, 8'h80, "R6 write one keeps flag");
        chk_irq(1'b0, "R7 irq needs enable");
        wr(4'd14, 8'h90);
        chk_irq(1'b1, "R7 irq flag and enable");
        chk_reg(4'd14, 8'h90, "R11 ctrl1 readback");
        wr(4'd14, 8'h10);
        chk_reg(4'd14, 8'h10, "R6 write zero clears flag");
        chk_irq(1'b0, "R7 irq drops with flag");
        wr(4'd14, 8'h00);
    endtask

    task automatic t_ripple;
        set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h15, 8'h03, 8'h24);
        ticks(128);
        chk_reg(4'd1, 8'h00, "R4 sec wrap");
        chk_reg(4'd2, 8'h00, "R4 min wrap");
        chk_reg(4'd3, 8'h00, "R4 hour wrap");
        chk_reg(4'd4, 8'h00, "R4 weekday wrap");
        chk_reg(4'd5, 8'h16, "R4 mday step");
        chk_reg(4'd6, 8'h03, "R4 month kept");
    endtask

    task automatic month_case(input logic [7:0] md, mo, y, emd, emo, ey);
        set_time(8'h59, 8'h59, 8'h23, 8'h01, md, mo, y);
        ticks(128);
        chk_reg(4'd5, emd, "R5 day of month");
        chk_reg(4'd6, emo, "R5 month");
        chk_reg(4'd7, ey,  "R5 year");
    endtask

    task automatic t_months;
        month_case(8'h30, 8'h04, 8'h24, 8'h01, 8'h05, 8'h24);
        month_case(8'h30, 8'h05, 8'h24, 8'h31, 8'h05, 8'h24);
        month_case(8'h31, 8'h01, 8'h23, 8'h01, 8'h02, 8'h23);
        month_case(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23);
        month_case(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24);
        month_case(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, 8'h24);
        month_case(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, 8'h00);
        month_case(8'h28, 8'h02, 8'h10, 8'h01, 8'h03, 8'h10);
        month_case(8'h28, 8'h02, 8'h16, 8'h29, 8'h02, 8'h16);
        month_case(8'h30, 8'h11, 8'h12, 8'h01, 8'h12, 8'h12);
        month_case(8'h31, 8'h12, 8'h99, 8'h01, 8'h01, 8'h00);
    endtask

    task automatic t_run_writes_and_stop;
        set_time(8'h20, 8'h05, 8'h04, 8'h03, 8'h02, 8'h07, 8'h30);
        ticks(3);
        wr(4'd1, 8'h45);
        chk_reg(4'd1, 8'h20, "R8 seconds write ignored while running");
        wr(4'd0, 8'h55);
        chk_reg(4'd0, 8'h03, "R8 subsec write ignored");
        wr(4'd15, 8'h08);
        ticks(200);
        chk_reg(4'd0, 8'h03, "R9 subsec holds when stopped");
        chk_reg(4'd1, 8'h20, "R9 seconds hold when stopped");
        wr(4'd15, 8'h0A);
        @(negedge clk);
        chk_reg(4'd0, 8'h00, "R9 prescaler reset clears subsec");
        chk_reg(4'd15, 8'h0A, "R11 ctrl2 readback");
    endtask

    task automatic t_enable;
        set_time(8'h40, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
        wr(4'd15, 8'h01);
        ticks(130);
        chk_reg(4'd1, 8'h40, "R12 no count without enable");
        chk_reg(4'd0, 8'h00, "R12 subsec idle without enable");
        wr(4'd15, 8'hF9);
        chk_reg(4'd15, 8'h09, "R11 ctrl2 upper bits read zero");
    endtask

    task automatic t_adjust;
        set_time(8'h29, 8'h15, 8'h10, 8'h00, 8'h01, 8'h01, 8'h00);
        wr(4'd15, 8'h0C);
        @(negedge clk);
        chk_reg(4'd1, 8'h00, "R10 adjust below 30 seconds");
        chk_reg(4'd2, 8'h15, "R10 minutes kept below 30");
        chk_reg(4'd15, 8'h08, "R10 adjust bit self-clears");
        set_time(8'h45, 8'h59, 8'h10, 8'h00, 8'h01, 8'h01, 8'h00);
        wr(4'd15, 8'h0C);
        @(negedge clk);
        chk_reg(4'd1, 8'h00, "R10 adjust at 45 seconds");
        chk_reg(4'd2, 8'h00, "R10 minute carry ripples");
        chk_reg(4'd3, 8'h11, "R10 hour receives carry");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_subsec;
        t_flag;
        t_ripple;
        t_months;
        t_run_writes_and_stop;
        t_enable;
        t_adjust;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule